// File: doc/BRIEF.md
# Receive/Transmit FIFO Trigger and Flow Control

This block watches the occupancy of one serial channel's 16-entry receive queue and 16-entry transmit queue. From them it raises a receive-ready flag, a transmit-ready flag and an active-low request-to-send line. It does not store data. It takes the receive fill count and the transmit free-slot count from the FIFOs, and the mode bits from the channel's configuration registers.

The receive threshold is picked by two bits that live in two separate mode registers. The transmit threshold is measured in free slots, not in bytes held. When the receive timeout is enabled, a small idle watchdog raises the receive flag for a partly filled queue that has stopped changing. The flow-control output either tracks the receive threshold on its own or follows a software request bit.

Top module: `fifo_trig_flow`

## Requirements
- R1: While reset is high and on the first clock after it, rx_trig and tx_trig are 0 and rts_n is 1.
- R2: tx_lvl_sel selects the transmit threshold in free slots as follows: 00 gives 16, 01 gives 12, 10 gives 6 and 11 gives 1. tx_trig is 1 exactly when tx_free is greater than or equal to the selected threshold.
- R3: The receive selector is {rx_lvl_hi, rx_lvl_lo}. 00 gives 1 byte, 01 gives 6, 10 gives 12 and 11 gives 16. With the timeout not firing, rx_trig is 1 exactly when rx_fill is greater than or equal to the selected threshold.
- R4: All three outputs are registered. Each shows the result of the inputs sampled at the previous rising clock edge.
- R5: With auto_rts_en = 1, rts_n is 1 when rx_fill is at or above the receive threshold, and 0 when it is below.
- R6: With auto_rts_en = 0, rts_n equals the inverse of sw_rts_req, whatever rx_fill is.
- R7: With rx_tmo_en = 1, and rx_fill nonzero, below the threshold and unchanged, rx_trig becomes 1 on the (TIMEOUT_CYC+1)-th edge after the last change of rx_fill. It stays 1 while rx_fill holds.
- R8: With rx_tmo_en = 0, or with rx_fill = 0, a below-threshold rx_fill never sets rx_trig, however long it holds.
- R9: A change of rx_fill restarts the idle timing. After a timeout, a new below-threshold value leaves rx_trig at 0 from the second edge after the change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_fill | input | CNT_W | Bytes held in the receive FIFO |
| tx_free | input | CNT_W | Empty slots in the transmit FIFO |
| tx_lvl_sel | input | 2 | Transmit threshold select |
| rx_lvl_hi | input | 1 | Receive threshold select, high bit |
| rx_lvl_lo | input | 1 | Receive threshold select, low bit |
| auto_rts_en | input | 1 | Automatic flow control enable |
| rx_tmo_en | input | 1 | Receive idle timeout enable |
| sw_rts_req | input | 1 | Software request-to-send (1 = assert) |
| rx_trig | output | 1 | Receive-ready flag |
| tx_trig | output | 1 | Transmit-ready flag |
| rts_n | output | 1 | Request-to-send, active low |

## Verification
The threshold flags and rts_n are due one edge after the inputs that cause them. The driver applies each input set at a falling edge and queues its expectation after the next rising edge. The monitor compares at the falling edge that follows, so every comparison lands on the edge the result is due. The timeout result is due TIMEOUT_CYC+1 edges after the last fill change. The bench counts edges from that change and asserts the flag low up to that edge and high after it. The one edge where a fill change meets an already expired timer is marked don't-care for rx_trig.

// File: rtl/fifo_trig_pkg.sv
package fifo_trig_pkg;

  // Transmit threshold in free slots, scaled from the FIFO depth.
  function automatic int unsigned tx_level(input logic [1:0] sel, input int unsigned depth);
    case (sel)
      2'b00:   return depth;
      2'b01:   return (depth * 3) / 4;
      2'b10:   return (depth * 3) / 8;
      default: return 1;
    endcase
  endfunction

  // Receive threshold in bytes held.
  function automatic int unsigned rx_level(input logic [1:0] sel, input int unsigned depth);
    case (sel)
      2'b00:   return 1;
      2'b01:   return (depth * 3) / 8;
      2'b10:   return (depth * 3) / 4;
      default: return depth;
    endcase
  endfunction

endpackage

// File: rtl/level_detect.sv
module level_detect
  import fifo_trig_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int CNT_W = 5,
  parameter bit IS_RX = 1'b0
) (
  input  logic [CNT_W-1:0] count,
  input  logic [1:0]       sel,
  output logic             hit
);

  logic [CNT_W-1:0] lvl;

  generate
    if (IS_RX) begin : g_rx
      always_comb lvl = CNT_W'(rx_level(sel, DEPTH));
    end else begin : g_tx
      always_comb lvl = CNT_W'(tx_level(sel, DEPTH));
    end
  endgenerate

  assign hit = (count >= lvl);

endmodule

// File: rtl/rx_idle_watch.sv
module rx_idle_watch #(
  parameter int CNT_W       = 5,
  parameter int TIMEOUT_CYC = 64,
  localparam int TW         = $clog2(TIMEOUT_CYC + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic [CNT_W-1:0] fill,
  output logic             expired
);

  logic [CNT_W-1:0] fill_prev;
  logic [TW-1:0]    idle_cnt;
  logic             restart;

  assign restart = !en || (fill == '0) || (fill != fill_prev);

  always_ff @(posedge clk) begin
    if (rst) begin
      fill_prev <= '0;
      idle_cnt  <= '0;
    end else begin
      fill_prev <= fill;
      if (restart)
        idle_cnt <= '0;
      else if (idle_cnt != TW'(TIMEOUT_CYC))
        idle_cnt <= idle_cnt + 1'b1;
    end
  end

  assign expired = (idle_cnt == TW'(TIMEOUT_CYC));

  // R8
  tmo_off_clears_chk: assert property (@(posedge clk) disable iff (rst)
    !en |=> (idle_cnt == '0));

  // R8
  empty_never_times_chk: assert property (@(posedge clk) disable iff (rst)
    (fill == '0) |=> !expired);

endmodule

// File: rtl/rts_drive.sv
module rts_drive (
  input  logic clk,
  input  logic rst,
  input  logic auto_en,
  input  logic rx_hit,
  input  logic sw_req,
  output logic rts_n
);

  logic seen_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      rts_n  <= 1'b1;
      seen_q <= 1'b0;
    end else begin
      rts_n  <= auto_en ? rx_hit : !sw_req;
      seen_q <= 1'b1;
    end
  end

  // R6
  manual_follow_chk: assert property (@(posedge clk) disable iff (rst)
    (seen_q && !$past(auto_en)) |-> (rts_n == !$past(sw_req)));

  // R1
  reset_idle_chk: assert property (@(posedge clk)
    $past(rst) |-> rts_n);

endmodule

// File: rtl/fifo_trig_flow.sv
module fifo_trig_flow #(
  parameter int  DEPTH       = 16,
  parameter int  TIMEOUT_CYC = 64,
  localparam int CNT_W       = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] rx_fill,
  input  logic [CNT_W-1:0] tx_free,
  input  logic [1:0]       tx_lvl_sel,
  input  logic             rx_lvl_hi,
  input  logic             rx_lvl_lo,
  input  logic             auto_rts_en,
  input  logic             rx_tmo_en,
  input  logic             sw_rts_req,
  output logic             rx_trig,
  output logic             tx_trig,
  output logic             rts_n
);

  logic tx_hit, rx_hit, tmo_hit, seen_q;

  level_detect #(.DEPTH(DEPTH), .CNT_W(CNT_W), .IS_RX(1'b0)) u_tx_lvl (
    .count (tx_free),
    .sel   (tx_lvl_sel),
    .hit   (tx_hit)
  );

  level_detect #(.DEPTH(DEPTH), .CNT_W(CNT_W), .IS_RX(1'b1)) u_rx_lvl (
    .count (rx_fill),
    .sel   ({rx_lvl_hi, rx_lvl_lo}),
    .hit   (rx_hit)
  );

  rx_idle_watch #(.CNT_W(CNT_W), .TIMEOUT_CYC(TIMEOUT_CYC)) u_idle (
    .clk     (clk),
    .rst     (rst),
    .en      (rx_tmo_en),
    .fill    (rx_fill),
    .expired (tmo_hit)
  );

  rts_drive u_rts (
    .clk     (clk),
    .rst     (rst),
    .auto_en (auto_rts_en),
    .rx_hit  (rx_hit),
    .sw_req  (sw_rts_req),
    .rts_n   (rts_n)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rx_trig <= 1'b0;
      tx_trig <= 1'b0;
      seen_q  <= 1'b0;
    end else begin
      rx_trig <= rx_hit || tmo_hit;
      tx_trig <= tx_hit;
      seen_q  <= 1'b1;
    end
  end

  // R2
  tx_all_free_chk: assert property (@(posedge clk) disable iff (rst)
    (seen_q && $past(tx_free) == CNT_W'(DEPTH)) |-> tx_trig);

  // R2
  tx_none_free_chk: assert property (@(posedge clk) disable iff (rst)
    (seen_q && $past(tx_free) == '0) |-> !tx_trig);

  // R3
  rx_full_chk: assert property (@(posedge clk) disable iff (rst)
    (seen_q && $past(rx_fill) == CNT_W'(DEPTH)) |-> rx_trig);

  // R5
  rts_empty_chk: assert property (@(posedge clk) disable iff (rst)
    (seen_q && $past(auto_rts_en) && $past(rx_fill) == '0) |-> !rts_n);

  // R1
  flags_reset_chk: assert property (@(posedge clk)
    $past(rst) |-> (!rx_trig && !tx_trig));

endmodule

// File: tb/fifo_trig_flow_tb_top.sv
`timescale 1ns/1ps
module fifo_trig_flow_tb_top;

  localparam int DEPTH = 16;
  localparam int TMO   = 8;
  localparam int CW    = $clog2(DEPTH + 1);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [CW-1:0] rx_fill = '0, tx_free = '0;
  logic [1:0] tx_lvl_sel = 2'b00;
  logic rx_lvl_hi = 1'b0, rx_lvl_lo = 1'b0;
  logic auto_rts_en = 1'b0, rx_tmo_en = 1'b0, sw_rts_req = 1'b0;
  logic rx_trig, tx_trig, rts_n;

  int n_chk = 0, n_fail = 0;

  typedef struct {
    logic  rx, tx, rts;
    bit    care_rx;
    string tag;
  } exp_t;

  exp_t q[$];

  always #5 clk = ~clk;

  fifo_trig_flow #(.DEPTH(DEPTH), .TIMEOUT_CYC(TMO)) dut_i (
    .clk(clk), .rst(rst), .rx_fill(rx_fill), .tx_free(tx_free),
    .tx_lvl_sel(tx_lvl_sel), .rx_lvl_hi(rx_lvl_hi), .rx_lvl_lo(rx_lvl_lo),
    .auto_rts_en(auto_rts_en), .rx_tmo_en(rx_tmo_en), .sw_rts_req(sw_rts_req),
    .rx_trig(rx_trig), .tx_trig(tx_trig), .rts_n(rts_n)
  );

  function automatic int tx_thr(input logic [1:0] s);
    int t[4] = '{16, 12, 6, 1};
    return t[s];
  endfunction

  function automatic int rx_thr(input logic [1:0] s);
    int t[4] = '{1, 6, 12, 16};
    return t[s];
  endfunction

  task automatic check(input string tag, input string what, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %b expected %b", tag, what, act, exp);
    end
  endtask

  // rxmode: 0 = model, 1 = expect 1, 2 = expect 0, 3 = don't care
  task automatic step(input int fill, input int free, input logic [1:0] ts,
                      input logic rh, input logic rl, input logic au,
                      input logic tm, input logic sw, input int rxmode,
                      input string tag);
    exp_t e;
    logic rxh;
    @(negedge clk);
    rx_fill = CW'(fill); tx_free = CW'(free); tx_lvl_sel = ts;
    rx_lvl_hi = rh; rx_lvl_lo = rl; auto_rts_en = au; rx_tmo_en = tm; sw_rts_req = sw;
    rxh = (fill >= rx_thr({rh, rl}));
    e.tx = (free >= tx_thr(ts));
    e.rts = au ? rxh : !sw;
    e.rx = (rxmode == 1) ? 1'b1 : (rxmode == 2) ? 1'b0 : rxh;
    e.care_rx = (rxmode != 3);
    e.tag = tag;
    @(posedge clk);
    #1 q.push_back(e);
  endtask

  // monitor: results due one edge after the inputs (R4)
  always @(negedge clk) begin
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      check(e.tag, "tx_trig", tx_trig, e.tx);
      check(e.tag, "rts_n", rts_n, e.rts);
      if (e.care_rx) check(e.tag, "rx_trig", rx_trig, e.rx);
    end
  end

  initial begin
    #(200000 * 10);
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    int vals[8] = '{0, 1, 5, 6, 11, 12, 15, 16};
    repeat (3) @(negedge clk);
    check("R1", "rx_trig", rx_trig, 1'b0);
    check("R1", "tx_trig", tx_trig, 1'b0);
    check("R1", "rts_n", rts_n, 1'b1);
    rst = 1'b0;

    // R2 transmit thresholds, R4 one-edge latency
    for (int s = 0; s < 4; s++)
      for (int i = 0; i < 8; i++)
        step(0, vals[i], 2'(s), 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 0, "R2");

    // R3 receive thresholds split across two bits, R5 automatic flow control
    for (int s = 0; s < 4; s++)
      for (int i = 0; i < 8; i++)
        step(vals[i], 16, 2'b00, s[1], s[0], 1'b1, 1'b0, 1'b0, 0, "R3_R5");

    // R6 manual flow control ignores fill
    step(16, 0, 2'b00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 0, "R6");
    step(16, 0, 2'b00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 0, "R6");
    step(0,  0, 2'b00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 0, "R6");
    step(0,  0, 2'b00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 0, "R6");

    // R8 timeout disabled: below-threshold fill held long
    for (int k = 0; k < 3 * TMO; k++)
      step(3, 0, 2'b00, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 2, "R8");
    // R8 empty FIFO with timeout enabled
    for (int k = 0; k < 3 * TMO; k++)
      step(0, 0, 2'b00, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 2, "R8");

    // R7 timeout: fill changes to 3 (threshold 6) then holds
    for (int k = 0; k <= TMO; k++)
      step(3, 0, 2'b00, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 2, "R7");
    for (int k = 0; k < 3; k++)
      step(3, 0, 2'b00, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1, "R7");

    // R9 new value restarts timing
    step(4, 0, 2'b00, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 3, "R9");
    for (int k = 0; k < 4; k++)
      step(4, 0, 2'b00, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 2, "R9");

    repeat (3) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule